// File: doc/BRIEF.md
# Receive byte queue with fill trigger and idle timeout

This block holds the bytes that the receive side of a serial port has taken in, until software collects them. A deserialiser or a loopback path offers each new byte with a one-cycle valid strobe. A read of the data register pops the oldest byte with a one-cycle pop strobe, and that byte is returned on a registered output. The queue holds 16 bytes. It keeps five status levels: empty, full, overflow, fill trigger and idle timeout. For each level it also gives a one-cycle event pulse that an interrupt block can latch.

The fill trigger compares the byte count with a programmable level, which resets to 32. The idle timeout fires when the queue holds data and no byte has arrived for four character times. The character time is given in clock cycles by the frame configuration logic. A flush command empties the queue. Two control bits gate all traffic: an enable bit and a disable bit. Reads and writes take effect only when the enable bit is set and the disable bit is clear.

Top module: `rx_byte_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block comes out with `fill_count` 0, `rd_data` 0x00, `events` 0 and `status` 5'b00001. The status bits are: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 trigger, bit 4 timeout. The trigger level starts at 32.
- R2: Bytes are returned on `rd_data` in arrival order, one cycle after the pop strobe. `fill_count` gives the number of bytes held. The empty bit is 1 exactly when the queue holds no bytes.
- R3: A byte offered while 16 bytes are held, with no pop in the same cycle, is dropped. This sets status bit 2 (overflow).
- R4: Status bit 1 (full) is set when an accepted byte brings the count to 16. Any read clears it.
- R5: Any read, including a read of an empty queue, clears the overflow bit.
- R6: A read while the queue is empty returns 0x00 and leaves the empty bit at 1.
- R7: Status bit 3 (trigger) is set after an accepted write that leaves the count at or above the level. It is cleared after a read that leaves the count below the level. Nothing else changes it, and a flush does not change it either.
- R8: Each accepted byte loads a countdown of 4 × `char_cycles` cycles and clears the timeout bit. The countdown advances only while the queue holds bytes. When it reaches zero it sets status bit 4 (timeout). A `char_cycles` value of 0 never fires.
- R9: `rx_flush` empties the queue, sets the empty bit and clears full, overflow and timeout. It wins over a push or pop in the same cycle, and a pop in that cycle leaves `rd_data` unchanged.
- R10: Unless `rx_en` is 1 and `rx_dis` is 0, pushes and pops have no effect: `fill_count`, `status` and `rd_data` hold.
- R11: When a push and a pop arrive in the same cycle, the pop is taken first. A full queue therefore accepts the new byte, and no overflow is flagged.
- R12: Each `events` bit pulses for exactly one cycle, in the first cycle its `status` bit reads 1 after having read 0.
- R13: A write through `lvl_we`/`lvl_in` sets the trigger level. The new level is used for every push and pop after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable bit |
| rx_dis | input | 1 | Receive disable bit; overrides the enable bit |
| rx_flush | input | 1 | Receiver flush command (one-cycle pulse) |
| in_valid | input | 1 | A new byte is offered on `in_data` |
| in_data | input | DATA_W | Incoming byte |
| rd_pop | input | 1 | Data-register read strobe |
| rd_data | output | DATA_W | Byte returned by the last accepted read |
| lvl_we | input | 1 | Trigger level write strobe |
| lvl_in | input | LVL_W | New trigger level |
| char_cycles | input | CHAR_W | Clock cycles per character |
| fill_count | output | $clog2(DEPTH+1) | Number of bytes held |
| status | output | 5 | Status levels: empty, full, overflow, trigger, timeout (bits 0 to 4) |
| events | output | 5 | One-cycle pulses on the rising edge of each status bit |

## Verification
The bench uses the default parameters: a depth of 16, a 6-bit trigger level that resets to 32, and a 16-bit character time. With a depth of 16, the queue can be filled and overrun within a few dozen cycles. The reset level of 32 keeps the trigger quiet until the bench writes levels between 0 and 20, and those levels reach both sides of the compare. The bench drives `char_cycles` between 0 and 3, so each timeout expires within 12 cycles and the disabled zero case is also covered.

// File: rtl/rxq_pkg.sv
// Shared definitions for the receive byte queue.
// Assumes: the status and event vectors use the bit order given here.
package rxq_pkg;
    localparam int FLAG_N   = 5;
    localparam int FL_EMPTY = 0;
    localparam int FL_FULL  = 1;
    localparam int FL_OVR   = 2;
    localparam int FL_TRIG  = 3;
    localparam int FL_TMO   = 4;

    typedef logic [FLAG_N-1:0] rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
// Byte storage with read and write pointers and a fill count.
// Assumes: push and pop arrive already qualified. A pop only comes when
// bytes are held. A push only comes when there is room after this cycle's pop.
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;

    // Next pointer value, with wrap at the last slot.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // One write enable per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wptr == PTR_W'(i))) mem[i] <= wdata;
        end
    end

    // Oldest byte, presented for the top to capture.
    assign head = mem[rptr];

    // Pointer and count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/rxq_timer.sv
// Idle timeout countdown, in whole character times.
// Assumes: load is an accepted byte. run is high while the queue holds data.
// expire is a one-cycle combinational strobe on the last step of the countdown.
module rxq_timer #(
    parameter int CHAR_W    = 16,
    parameter int TMO_CHARS = 4,
    localparam int TMR_W    = CHAR_W + $clog2(TMO_CHARS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              run,
    input  logic [CHAR_W-1:0] char_cycles,
    output logic              expire
);
    logic [TMR_W-1:0] remain;
    logic [TMR_W-1:0] span;

    // Full window length for the current character time.
    assign span   = TMR_W'(char_cycles) * TMR_W'(TMO_CHARS);
    assign expire = run && !load && !clear && (remain == TMR_W'(1));

    // Reload on each accepted byte, count down while data is held.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            remain <= '0;
        end else if (load) begin
            remain <= span;
        end else if (run && (remain != '0)) begin
            remain <= remain - TMR_W'(1);
        end
    end
endmodule

// File: rtl/rxq_flags.sv
// Status level rules and their rising-edge event pulses.
// Assumes: rd is an active read and wr_ok is an accepted byte. wr_drop is a byte
// refused for lack of room. cnt_mid is the count after the pop and cnt_new is the
// count after both operations.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rd,
    input  logic             wr_ok,
    input  logic             wr_drop,
    input  logic             expire,
    input  logic [CNT_W-1:0] cnt_mid,
    input  logic [CNT_W-1:0] cnt_new,
    input  logic [LVL_W-1:0] level,
    output rxq_flags_t       flags,
    output rxq_flags_t       pulses
);
    rxq_flags_t nxt;

    // Flag updates: read effects first, then write effects, then timeout.
    always_comb begin
        nxt = flags;
        if (clear) begin
            nxt[FL_EMPTY] = 1'b1;
            nxt[FL_FULL]  = 1'b0;
            nxt[FL_OVR]   = 1'b0;
            nxt[FL_TMO]   = 1'b0;
        end else begin
            if (rd) begin
                nxt[FL_FULL] = 1'b0;
                nxt[FL_OVR]  = 1'b0;
                if (cnt_mid == '0) nxt[FL_EMPTY] = 1'b1;
                if (CMP_W'(cnt_mid) < CMP_W'(level)) nxt[FL_TRIG] = 1'b0;
            end
            if (wr_ok) begin
                nxt[FL_EMPTY] = 1'b0;
                nxt[FL_TMO]   = 1'b0;
                if (cnt_new == CNT_W'(DEPTH)) nxt[FL_FULL] = 1'b1;
                if (CMP_W'(cnt_new) >= CMP_W'(level)) nxt[FL_TRIG] = 1'b1;
            end
            if (wr_drop) nxt[FL_OVR] = 1'b1;
            if (expire)  nxt[FL_TMO] = 1'b1;
        end
    end

    // Register the levels and flag each 0-to-1 change for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= rxq_flags_t'(1 << FL_EMPTY);
            pulses <= '0;
        end else begin
            flags  <= nxt;
            pulses <= nxt & ~flags;
        end
    end
endmodule

// File: rtl/rx_byte_queue.sv
// Receive byte queue: storage, status levels, trigger level register and idle
// timeout. It qualifies the incoming strobes and registers the byte returned by a read.
// Assumes: in_valid and rd_pop are single-cycle strobes. A flush overrides both.
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 8,
    parameter int LVL_W     = 6,
    parameter int LVL_RST   = 32,
    parameter int CHAR_W    = 16,
    parameter int TMO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_dis,
    input  logic              rx_flush,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lvl_we,
    input  logic [LVL_W-1:0]  lvl_in,
    input  logic [CHAR_W-1:0] char_cycles,
    output logic [CNT_W-1:0]  fill_count,
    output logic [FLAG_N-1:0] status,
    output logic [FLAG_N-1:0] events
);
    logic              active;
    logic              rd_req;
    logic              pop_ok;
    logic              wr_req;
    logic              wr_ok;
    logic              wr_drop;
    logic [CNT_W-1:0]  cnt_mid;
    logic [CNT_W-1:0]  cnt_new;
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;
    logic              expire;

    // Qualify the strobes. A pop is taken before a push in the same cycle.
    assign active  = rx_en && !rx_dis;
    assign rd_req  = active && rd_pop && !rx_flush;
    assign pop_ok  = rd_req && (fill_count != '0);
    assign cnt_mid = fill_count - CNT_W'(pop_ok);
    assign wr_req  = active && in_valid && !rx_flush;
    assign wr_ok   = wr_req && (cnt_mid != CNT_W'(DEPTH));
    assign wr_drop = wr_req && (cnt_mid == CNT_W'(DEPTH));
    assign cnt_new = cnt_mid + CNT_W'(wr_ok);

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_flush),
        .push  (wr_ok),
        .pop   (pop_ok),
        .wdata (in_data),
        .head  (head),
        .count (fill_count)
    );

    rxq_timer #(.CHAR_W(CHAR_W), .TMO_CHARS(TMO_CHARS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (rx_flush),
        .load        (wr_ok),
        .run         (fill_count != '0),
        .char_cycles (char_cycles),
        .expire      (expire)
    );

    rxq_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rx_flush),
        .rd      (rd_req),
        .wr_ok   (wr_ok),
        .wr_drop (wr_drop),
        .expire  (expire),
        .cnt_mid (cnt_mid),
        .cnt_new (cnt_new),
        .level   (level),
        .flags   (status),
        .pulses  (events)
    );

    // Trigger level register.
    always_ff @(posedge clk) begin
        if (!rst_n)      level <= LVL_W'(LVL_RST);
        else if (lvl_we) level <= lvl_in;
    end

    // Read data: oldest byte, or zero when the queue is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= pop_ok ? head : '0;
    end
endmodule

// File: rtl/rxq_checker.sv
// Protocol checks for the receive byte queue, attached by bind.
// Assumes: status and events follow the bit order in rxq_pkg.
module rxq_checker
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rx_dis,
    input logic              rx_flush,
    input logic              in_valid,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  fill_count,
    input logic [FLAG_N-1:0] status,
    input logic [FLAG_N-1:0] events
);
    logic on;
    assign on = rx_en && !rx_dis;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (fill_count == '0 && rd_data == '0 && events == '0 && status == FLAG_N'(1)));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (on && in_valid && !rd_pop && !rx_flush && fill_count == CNT_W'(DEPTH))
        |=> (fill_count == CNT_W'(DEPTH) && status[FL_OVR]));

    a_r4_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        status[FL_FULL] == (fill_count == CNT_W'(DEPTH)));

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (on && rd_pop && !rx_flush && fill_count == '0) |=> (rd_data == '0));

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (fill_count == '0 && status[FL_EMPTY] && !status[FL_FULL]
                      && !status[FL_OVR] && !status[FL_TMO]));

    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && !rx_flush) |=> ($stable(fill_count) && $stable(rd_data)));

    a_r12_event_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (events & ~status) == '0);

    a_r12_event_single: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((events & $past(events)) == '0));
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rx_dis     (rx_dis),
    .rx_flush   (rx_flush),
    .in_valid   (in_valid),
    .rd_pop     (rd_pop),
    .rd_data    (rd_data),
    .fill_count (fill_count),
    .status     (status),
    .events     (events)
);

// File: tb/rx_byte_queue_test.sv
`timescale 1ns/1ps
module rx_byte_queue_test;
    localparam int DEPTH  = 16;
    localparam int LVL_W  = 6;
    localparam int CHAR_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rx_dis = 1'b0, rx_flush = 1'b0;
    logic in_valid = 1'b0, rd_pop = 1'b0, lvl_we = 1'b0;
    logic [7:0] in_data = '0;
    logic [LVL_W-1:0] lvl_in = '0;
    logic [CHAR_W-1:0] char_cycles = '0;
    logic [7:0] rd_data;
    logic [4:0] fill_count;
    logic [4:0] status, events;

    rx_byte_queue uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_dis(rx_dis), .rx_flush(rx_flush),
        .in_valid(in_valid), .in_data(in_data), .rd_pop(rd_pop), .rd_data(rd_data),
        .lvl_we(lvl_we), .lvl_in(lvl_in), .char_cycles(char_cycles),
        .fill_count(fill_count), .status(status), .events(events)
    );

    always #2 clk = ~clk;

    // Expected state, from the requirements (bits: 0 empty,1 full,2 ovr,3 trig,4 tmo).
    logic [7:0] mq[$];
    logic [7:0] m_out;
    logic [4:0] m_st, m_ev;
    int m_lvl, m_tmr;
    int n_checks = 0, n_errors = 0;
    bit done = 0;

    task automatic model_reset();
        mq.delete(); m_out = 8'h00; m_st = 5'b00001; m_ev = '0; m_lvl = 32; m_tmr = 0;
    endtask

    // Apply the inputs now driven to the model, as of the coming clock edge.
    task automatic model_step();
        logic [4:0] old = m_st;
        bit act = rx_en && !rx_dis;
        bit run = (mq.size() != 0);
        bit loaded = 0;
        if (rx_flush) begin
            mq.delete(); m_st[0] = 1; m_st[1] = 0; m_st[2] = 0; m_st[4] = 0; m_tmr = 0;
        end else begin
            if (act && rd_pop) begin
                if (mq.size() > 0) m_out = mq.pop_front(); else m_out = 8'h00;
                m_st[1] = 0; m_st[2] = 0;
                if (mq.size() == 0) m_st[0] = 1;
                if (mq.size() < m_lvl) m_st[3] = 0;
            end
            if (act && in_valid) begin
                if (mq.size() == DEPTH) m_st[2] = 1;
                else begin
                    mq.push_back(in_data);
                    m_st[0] = 0; m_st[4] = 0;
                    if (mq.size() == DEPTH) m_st[1] = 1;
                    if (mq.size() >= m_lvl) m_st[3] = 1;
                    m_tmr = 4 * int'(char_cycles);
                    loaded = 1;
                end
            end
            if (!loaded && run && m_tmr != 0) begin
                if (m_tmr == 1) m_st[4] = 1;
                m_tmr--;
            end
        end
        if (lvl_we) m_lvl = int'(lvl_in);
        m_ev = m_st & ~old;
    endtask

    function automatic string pick(string tag, string dflt);
        return (tag == "") ? dflt : tag;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk(pick(tag, "R2"),  "rd_data",    int'(rd_data),    int'(m_out));
        chk(pick(tag, "R2"),  "fill_count", int'(fill_count), mq.size());
        chk(pick(tag, "R2"),  "empty",      int'(status[0]),  int'(m_st[0]));
        chk(pick(tag, "R4"),  "full",       int'(status[1]),  int'(m_st[1]));
        chk(pick(tag, "R3"),  "overflow",   int'(status[2]),  int'(m_st[2]));
        chk(pick(tag, "R7"),  "trigger",    int'(status[3]),  int'(m_st[3]));
        chk(pick(tag, "R8"),  "timeout",    int'(status[4]),  int'(m_st[4]));
        chk(pick(tag, "R12"), "events",     int'(events),     int'(m_ev));
    endtask

    // Advance one cycle from a falling edge and check at the next one.
    task automatic tick(string tag);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic push_byte(logic [7:0] b, string tag);
        in_valid = 1; in_data = b; tick(tag); in_valid = 0;
    endtask

    task automatic pop_one(string tag);
        rd_pop = 1; tick(tag); rd_pop = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5117));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        tick("R1");

        // R10: traffic while not enabled is ignored.
        push_byte(8'h11, "R10");
        pop_one("R10");
        rx_en = 1; rx_dis = 1;
        push_byte(8'h22, "R10");

        rx_dis = 0;
        push_byte(8'hA5, "R2");
        push_byte(8'h3C, "R2");
        pop_one("R2");
        pop_one("R2");
        pop_one("R6");
        pop_one("R6");

        // Fill, overrun, and the clears that any read brings.
        for (int i = 0; i < DEPTH; i++) push_byte(8'(i * 7 + 1), "R4");
        push_byte(8'hEE, "R3");
        push_byte(8'hEF, "R3");
        rx_dis = 1; pop_one("R10"); rx_dis = 0;
        in_valid = 1; in_data = 8'h5A; rd_pop = 1; tick("R11");
        in_valid = 0; rd_pop = 0;
        push_byte(8'h66, "R3");
        pop_one("R5");
        pop_one("R4");

        // Trigger level at 4.
        rx_flush = 1; tick("R9"); rx_flush = 0;
        lvl_we = 1; lvl_in = 6'd4; tick("R13"); lvl_we = 0;
        for (int i = 0; i < 5; i++) push_byte(8'(8'h40 + i), "R7");
        pop_one("R7");
        pop_one("R7");
        rx_flush = 1; tick("R7");
        rx_flush = 0;

        // Timeout: four characters of two cycles each.
        char_cycles = 2;
        push_byte(8'h77, "R8");
        repeat (10) tick("R8");
        push_byte(8'h78, "R8");
        repeat (4) tick("R8");
        pop_one("R8");
        pop_one("R8");
        repeat (10) tick("R8");
        char_cycles = 0;
        push_byte(8'h79, "R8");
        repeat (6) tick("R8");

        // Flush wins over a same-cycle push and pop.
        rx_flush = 1; in_valid = 1; in_data = 8'h99; rd_pop = 1; tick("R9");
        rx_flush = 0; in_valid = 0; rd_pop = 0;
        tick("R9");

        // Random traffic in four biased phases.
        for (int n = 0; n < 6000; n++) begin
            int ph = (n / 500) % 4;
            int pw = (ph == 0) ? 70 : (ph == 1) ? 30 : (ph == 2) ? 50 : 10;
            int pr = (ph == 0) ? 25 : (ph == 1) ? 60 : (ph == 2) ? 50 : 8;
            if (n % 500 == 0) char_cycles = CHAR_W'($urandom_range(0, 3));
            in_valid = ($urandom_range(0, 99) < pw);
            in_data  = 8'($urandom);
            rd_pop   = ($urandom_range(0, 99) < pr);
            rx_flush = ($urandom_range(0, 199) == 0);
            rx_dis   = ($urandom_range(0, 49) == 0);
            rx_en    = ($urandom_range(0, 59) != 0);
            lvl_we   = ($urandom_range(0, 79) == 0);
            lvl_in   = LVL_W'($urandom_range(0, 20));
            tick("");
        end
        finish_run();
    end
endmodule